// File: doc/BRIEF.md
# Victim Buffer Swap Unit

This block is a small fully-associative store of block tags, each with a valid bit and a dirty bit, that sits next to a set-associative main cache. It holds lines the main cache has thrown out. The main cache consults it only when a lookup misses and the indexed set has no free way. In that case the main cache sends one swap request. The request carries the wanted tag X and the tag and dirty bit of the line V that the main cache is about to evict.

If X is resident, the unit reports a hit and returns X's dirty bit. V takes over the entry X occupied, and that entry becomes the most recently used. If X is absent, the unit first makes room for V. It takes the lowest-numbered free entry if one exists. Otherwise it takes its least recently used entry V2, which is sent to the next level through a ready/valid port when dirty and dropped when clean. V is then stored and marked most recently used, and a miss is reported. The requester may fetch X from the next level only after that miss response. Two counters tally accepted swap requests and successful swaps. When the enable input is low, or the entry count parameter is zero, the unit answers every request with a miss and changes nothing.

Top module: `victim_swap_buf`

## Requirements
- R1: After reset, no entry is valid, `rsp_valid` and `wb_valid` are low, `req_ready` is high and both counters are zero.
- R2: A request whose X tag matches a valid entry gets `rsp_valid` with `rsp_hit`=1 on the cycle after it is accepted, and `rsp_x_dirty` equal to the dirty bit stored with X. The V tag and V dirty bit are written into that same entry, so a later request for V returns V's dirty bit.
- R3: The entry written by any accepted, enabled request becomes most recently used. When the unit is full, a miss always replaces the valid entry that has gone longest without being written.
- R4: A miss while an entry is free stores V in the lowest-numbered free entry, produces no writeback, and gives `rsp_valid` with `rsp_hit`=0 on the next cycle.
- R5: A miss while every entry is valid evicts the least recently used entry. If that entry is dirty, its tag appears on `wb_tag` with `wb_valid` high before the response. If it is clean, no writeback occurs and the miss response follows on the next cycle.
- R6: Once `wb_valid` rises, it and `wb_tag` hold steady until a cycle with `wb_ready` high. `rsp_valid` is asserted one cycle after that handshake and never while `wb_valid` is high. `req_ready` is low while the writeback is pending.
- R7: A request accepted with `en` low is answered on the next cycle with `rsp_hit`=0. It writes no entry, causes no writeback and leaves both counters unchanged.
- R8: `swap_req_count` increments once per accepted request with `en` high. `swap_count` increments once per hit.
- R9: Every accepted request produces exactly one `rsp_valid` pulse, one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Unit enable, sampled with the request |
| req_valid | input | 1 | Swap request strobe |
| req_ready | output | 1 | High when a request can be accepted |
| req_x_tag | input | TAG_W | Tag of the wanted line X |
| req_v_tag | input | TAG_W | Tag of the line V leaving the main cache |
| req_v_dirty | input | 1 | Dirty bit of V |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | X was found and swapped |
| rsp_x_dirty | output | 1 | Dirty bit of X on a hit |
| wb_valid | output | 1 | Writeback of an evicted dirty entry pending |
| wb_ready | input | 1 | Next level accepts the writeback |
| wb_tag | output | TAG_W | Tag of the line being written back |
| swap_req_count | output | CNT_W | Accepted enabled swap requests |
| swap_count | output | CNT_W | Successful swaps |

## Verification
The assertions assume that the requester behaves as a main cache would. A request is raised only while `req_ready` is high. V is never already resident in the unit, because it came out of the main cache. X and V differ, and resident tags are unique. The bench enforces this by taking every V tag from a strictly increasing fresh-tag counter. X is either one of the currently resident tags, chosen from the bench's own model, or a fresh tag. The bench also issues each request only after the previous response has arrived. Writeback acceptance is delayed by zero to three cycles so that the handshake is held open.

// File: rtl/victim_swap_buf.sv
module victim_swap_buf #(
  parameter int ENTRIES = 4,
  parameter int TAG_W   = 24,
  parameter int CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [TAG_W-1:0] req_x_tag,
  input  logic [TAG_W-1:0] req_v_tag,
  input  logic             req_v_dirty,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_x_dirty,
  output logic             wb_valid,
  input  logic             wb_ready,
  output logic [TAG_W-1:0] wb_tag,
  output logic [CNT_W-1:0] swap_req_count,
  output logic [CNT_W-1:0] swap_count
);
  localparam int N  = (ENTRIES > 0) ? ENTRIES : 1;
  localparam int AW = (N > 1) ? $clog2(N) : 1;
  localparam bit ON = (ENTRIES > 0);
  localparam logic [AW-1:0] OLDEST = AW'(N - 1);

  logic [N-1:0]    ent_v, ent_d;
  logic [TAG_W-1:0] ent_t [N];
  logic [AW-1:0]   ent_age [N];

  logic            wb_pend;
  logic [AW-1:0]   held_idx;
  logic [TAG_W-1:0] held_tag;
  logic            held_dirty;

  logic [N-1:0]    match;
  logic            hit, any_free;
  logic [AW-1:0]   hit_idx, free_idx, lru_idx, slot;
  logic            accept, act, do_wr;
  logic [AW-1:0]   wr_idx, ref_age;
  logic [TAG_W-1:0] wr_tag;
  logic            wr_dirty;

  assign req_ready = !wb_pend;
  assign wb_valid  = wb_pend;
  assign accept    = req_valid && !wb_pend;
  assign act       = accept && en && ON;

  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    lru_idx  = '0;
    any_free = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      match[i] = ent_v[i] && (ent_t[i] == req_x_tag);
      if (match[i]) hit_idx = AW'(i);
      if (!ent_v[i]) begin
        free_idx = AW'(i);
        any_free = 1'b1;
      end
      if (ent_v[i] && ent_age[i] == OLDEST) lru_idx = AW'(i);
    end
    hit  = |match;
    slot = hit ? hit_idx : (any_free ? free_idx : lru_idx);
  end

  always_comb begin
    do_wr    = (act && (hit || any_free || !ent_d[lru_idx])) || (wb_pend && wb_ready);
    wr_idx   = wb_pend ? held_idx   : slot;
    wr_tag   = wb_pend ? held_tag   : req_v_tag;
    wr_dirty = wb_pend ? held_dirty : req_v_dirty;
    ref_age  = ent_v[wr_idx] ? ent_age[wr_idx] : OLDEST;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_v          <= '0;
      ent_d          <= '0;
      for (int i = 0; i < N; i++) begin
        ent_t[i]   <= '0;
        ent_age[i] <= '0;
      end
      wb_pend        <= 1'b0;
      held_idx       <= '0;
      held_tag       <= '0;
      held_dirty     <= 1'b0;
      wb_tag         <= '0;
      rsp_valid      <= 1'b0;
      rsp_hit        <= 1'b0;
      rsp_x_dirty    <= 1'b0;
      swap_req_count <= '0;
      swap_count     <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (accept && !act) begin
        rsp_valid   <= 1'b1;
        rsp_hit     <= 1'b0;
        rsp_x_dirty <= 1'b0;
      end
      if (act) begin
        swap_req_count <= swap_req_count + 1'b1;
        if (hit) begin
          swap_count  <= swap_count + 1'b1;
          rsp_valid   <= 1'b1;
          rsp_hit     <= 1'b1;
          rsp_x_dirty <= ent_d[hit_idx];
        end else if (!any_free && ent_d[lru_idx]) begin
          wb_pend    <= 1'b1;
          wb_tag     <= ent_t[lru_idx];
          held_idx   <= lru_idx;
          held_tag   <= req_v_tag;
          held_dirty <= req_v_dirty;
        end else begin
          rsp_valid   <= 1'b1;
          rsp_hit     <= 1'b0;
          rsp_x_dirty <= 1'b0;
        end
      end
      if (wb_pend && wb_ready) begin
        wb_pend     <= 1'b0;
        rsp_valid   <= 1'b1;
        rsp_hit     <= 1'b0;
        rsp_x_dirty <= 1'b0;
      end
      if (do_wr) begin
        for (int i = 0; i < N; i++) begin
          if (AW'(i) == wr_idx) begin
            ent_v[i]   <= 1'b1;
            ent_d[i]   <= wr_dirty;
            ent_t[i]   <= wr_tag;
            ent_age[i] <= '0;
          end else if (ent_v[i] && ent_age[i] < ref_age) begin
            ent_age[i] <= ent_age[i] + 1'b1;
          end
        end
      end
    end
  end

  AST_REQ_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_ready); // R6
  AST_UNIQUE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $onehot0(match)); // R2
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R9
  AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_tag))); // R6
  AST_WB_THEN_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_ready) |=> (rsp_valid && !rsp_hit && !wb_valid)); // R6
  AST_NO_RSP_IN_WB: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> !rsp_valid); // R6
  AST_OFF_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !en) |=> (rsp_valid && !rsp_hit && !wb_valid && $stable(swap_req_count))); // R7
  AST_HIT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> (swap_count == $past(swap_count) + 1'b1)); // R8
  AST_SWAPS_LE_REQS: assert property (@(posedge clk) disable iff (!rst_n)
    swap_count <= swap_req_count); // R8
endmodule

// File: tb/sim_victim_swap_buf.sv
`timescale 1ns/100ps
module sim_victim_swap_buf;
  localparam int E = 4;
  localparam int TW = 24;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1, req_valid = 1'b0, req_v_dirty = 1'b0, wb_ready = 1'b0;
  logic [TW-1:0] req_x_tag = '0, req_v_tag = '0;
  logic req_ready, rsp_valid, rsp_hit, rsp_x_dirty, wb_valid;
  logic [TW-1:0] wb_tag;
  logic [CW-1:0] swap_req_count, swap_count;

  always #2.5 clk = ~clk;

  victim_swap_buf #(.ENTRIES(E), .TAG_W(TW), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .req_valid(req_valid), .req_ready(req_ready),
    .req_x_tag(req_x_tag), .req_v_tag(req_v_tag), .req_v_dirty(req_v_dirty),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_x_dirty(rsp_x_dirty),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_tag(wb_tag),
    .swap_req_count(swap_req_count), .swap_count(swap_count));

  typedef struct {
    bit hit; bit xd; bit wb; logic [TW-1:0] wbt; string rq;
  } exp_t;
  exp_t q[$];

  int checks = 0, fails = 0, issued = 0, done = 0, wb_delay = 0;
  int exp_req = 0, exp_swp = 0;
  bit mv[E]; bit md[E]; logic [TW-1:0] mt[E]; int ord[$];
  logic [TW-1:0] fresh = 24'h200;

  task automatic chk(bit ok, string r, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  function automatic exp_t predict(logic [TW-1:0] x, logic [TW-1:0] v, bit vd, bit on, string rq);
    exp_t e; int s = -1;
    e.hit = 0; e.xd = 0; e.wb = 0; e.wbt = '0; e.rq = rq;
    if (!on) return e;
    exp_req++;
    for (int i = 0; i < E; i++) if (mv[i] && mt[i] == x) s = i;
    if (s >= 0) begin
      e.hit = 1; e.xd = md[s]; exp_swp++;
    end else begin
      for (int i = E - 1; i >= 0; i--) if (!mv[i]) s = i;
      if (s < 0) begin
        s = ord[ord.size() - 1];
        if (md[s]) begin e.wb = 1; e.wbt = mt[s]; end
      end
    end
    mv[s] = 1; md[s] = vd; mt[s] = v;
    for (int i = 0; i < ord.size(); i++) if (ord[i] == s) begin ord.delete(i); break; end
    ord.push_front(s);
    return e;
  endfunction

  task automatic swap(logic [TW-1:0] x, logic [TW-1:0] v, bit vd, bit on, int wd, string rq);
    while (!req_ready) @(negedge clk);
    wb_delay = wd;
    q.push_back(predict(x, v, vd, on, rq));
    issued++;
    req_x_tag = x; req_v_tag = v; req_v_dirty = vd; en = on; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; en = 1'b1;
    while (done < issued) @(negedge clk);
  endtask

  bit seen_wb = 0, prev_rsp = 0;
  logic [TW-1:0] seen_wbt = '0;
  int wcnt = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (wb_valid) begin
        chk(!rsp_valid, "R6", "rsp during writeback", rsp_valid, 0);
        chk(!req_ready, "R6", "ready during writeback", req_ready, 0);
        if (seen_wb) chk(wb_tag == seen_wbt, "R6", "wb_tag stable", wb_tag, seen_wbt);
        seen_wb = 1; seen_wbt = wb_tag;
        wb_ready = (wcnt >= wb_delay);
        wcnt++;
      end else begin
        wb_ready = 1'b0; wcnt = 0;
      end
      if (rsp_valid) begin
        exp_t e;
        chk(!prev_rsp, "R9", "pulse width", 1, 0);
        if (q.size() == 0) chk(0, "R9", "unexpected response", 1, 0);
        else begin
          e = q.pop_front();
          chk(rsp_hit == e.hit, e.rq, "rsp_hit", rsp_hit, e.hit);
          if (e.hit) chk(rsp_x_dirty == e.xd, e.rq, "rsp_x_dirty", rsp_x_dirty, e.xd);
          chk(seen_wb == e.wb, "R5", "writeback presence", seen_wb, e.wb);
          if (e.wb) chk(seen_wbt == e.wbt, "R5", "writeback tag", seen_wbt, e.wbt);
        end
        seen_wb = 0;
        done++;
      end
      prev_rsp = rsp_valid;
    end
  end

  task automatic check_counts(string rq);
    chk(swap_req_count == CW'(exp_req), rq, "swap_req_count", swap_req_count, exp_req);
    chk(swap_count == CW'(exp_swp), rq, "swap_count", swap_count, exp_swp);
  endtask

  function automatic logic [TW-1:0] nxt();
    fresh = fresh + 1'b1;
    return fresh;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "WDOG", "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < E; i++) begin mv[i] = 0; md[i] = 0; mt[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!rsp_valid, "R1", "rsp_valid", rsp_valid, 0);
    chk(!wb_valid, "R1", "wb_valid", wb_valid, 0);
    chk(req_ready, "R1", "req_ready", req_ready, 1);
    check_counts("R1");
    // R4 fill free entries: tags 0xA0..0xA3, dirty 0,1,0,1
    swap(24'h10, 24'hA0, 0, 1, 0, "R4");
    swap(24'h11, 24'hA1, 1, 1, 0, "R4");
    swap(24'h12, 24'hA2, 0, 1, 0, "R4");
    swap(24'h13, 24'hA3, 1, 1, 0, "R4");
    // R2 hit on dirty A1, V=B0 clean
    swap(24'hA1, 24'hB0, 0, 1, 0, "R2");
    // R5 full, LRU A0 clean dropped; then A2 clean
    swap(24'h20, 24'hB1, 1, 1, 0, "R5");
    swap(24'h21, 24'hB2, 0, 1, 0, "R5");
    // R5/R6 LRU A3 dirty, writeback held three cycles
    swap(24'h22, 24'hB3, 1, 1, 3, "R6");
    // R3 B0 was made MRU on swap and survived; R2 its dirty bit 0 returned
    swap(24'hB0, 24'hB4, 1, 1, 0, "R3");
    // R7 disabled request for resident B1 misses
    swap(24'hB1, 24'hB5, 0, 0, 0, "R7");
    check_counts("R7");
    // R7 state untouched: B1 still there with dirty 1
    swap(24'hB1, 24'hB6, 0, 1, 1, "R2");
    check_counts("R8");
    // mixed traffic
    for (int n = 0; n < 80; n++) begin
      logic [TW-1:0] x;
      int pick = $urandom % E;
      if (($urandom % 2) == 1 && mv[pick]) x = mt[pick];
      else x = nxt();
      swap(x, nxt(), 1'($urandom % 2), ($urandom % 8) != 0, $urandom % 4, "R3");
    end
    check_counts("R8");
    repeat (2) @(negedge clk);
    chk(q.size() == 0, "R9", "responses outstanding", q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule